// File: doc/BRIEF.md
# Supply Supervisor Reset Generator

This block turns a qualified undervoltage indication and a watchdog timeout request into the processor reset pair. While the supply flag reports a low rail, reset is held asserted. Once the rail recovers, reset stays asserted for a programmed number of slow timebase ticks. This keeps the processor in reset while its clock oscillator starts, and it stops reset from chattering when the supply drops out and returns on every line cycle.

A watchdog timeout request that arrives while the processor is running fires one reset pulse of the same stretched width. Each time reset ends, whatever caused it, the block emits a one-clock restart strobe, so that the watchdog begins a fresh period. The stretch width comes from a select input: a short setting of 512 ticks or a long setting of 2048 ticks. All logic runs on the system clock. The counter advances only on clocks where the tick enable is high.

Top module: `supply_reset_gen`

## Requirements
- R1: On the first clock edge that samples `lowLine` high, `resetN` goes low after that edge. It stays low for as long as `lowLine` remains high.
- R2: With `longSel` = 0, reset is released on the edge of the SHORT_TICKS-th (default 512) `tick` sampled after the edge that first sees `lowLine` low again.
- R3: With `longSel` = 1, the release comes after LONG_TICKS (default 2048) ticks, counted in the same way.
- R4: The width select is captured on the edge where a stretch begins. A change on `longSel` during the stretch does not alter that pulse.
- R5: While reset is released, a `wdTimeout` high on a clock edge (with `lowLine` low) asserts reset after that edge. It then releases reset after the width currently selected, counted from that edge.
- R6: A `wdTimeout` request sampled while reset is asserted is ignored and does not lengthen the pulse.
- R7: If `lowLine` rises during a stretch, the count is discarded. A full new stretch starts only when `lowLine` falls again.
- R8: `resetP` is always the exact complement of `resetN`.
- R9: `wdRestart` is high for exactly one clock: the first clock in which `resetN` is high after a reset, for both low-supply and watchdog resets. It is high at no other time.
- R10: While `rstN` is low, `resetN` is 0, `resetP` is 1 and `wdRestart` is 0. After `rstN` is released, a full stretch is run before reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| tick | input | 1 | Timebase enable; the stretch counts clocks where it is high |
| lowLine | input | 1 | Qualified flag, high while the supply is below threshold |
| wdTimeout | input | 1 | Watchdog timeout request, one clock wide |
| longSel | input | 1 | Stretch width select: 0 short, 1 long |
| resetN | output | 1 | Active-low processor reset |
| resetP | output | 1 | Active-high processor reset, complement of resetN |
| wdRestart | output | 1 | One-clock strobe when reset ends, restarts the watchdog |

## Verification
The bench drives the tick on every third clock, so a design that counted clocks instead of ticks, or that counted the tick on the starting edge, releases reset on the wrong cycle. The bench also checks several cases where the release cycle would move if the design were wrong:
- a watchdog request during a pulse, which would lengthen the pulse if it were not ignored;
- a low-line glitch in mid-stretch, which a design that did not clear the count would release early;
- a width select changed mid-pulse, which a design sampling it live would follow.

Every rising edge of reset must pop a predicted release cycle and coincide with a single restart strobe. A missing, extra or misplaced strobe is therefore caught.

// File: rtl/srg_pkg.sv
package srg_pkg;

  typedef enum logic [1:0] {
    ST_HOLD    = 2'd0,
    ST_STRETCH = 2'd1,
    ST_RUN     = 2'd2
  } srgState_t;

  typedef struct packed {
    logic startRun;   // clear counter, capture width select
    logic countEn;    // advance counter on tick
  } srgCtrl_t;

endpackage

// File: rtl/srg_datapath.sv
module srg_datapath
  import srg_pkg::*;
#(
  parameter int SHORT_TICKS = 512,
  parameter int LONG_TICKS  = 2048
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     tick,
  input  logic     longSel,
  input  srgCtrl_t ctrl,
  output logic     lastTick
);
  localparam int CNT_W = (LONG_TICKS > 1) ? $clog2(LONG_TICKS) : 1;
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_TICKS - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_TICKS - 1);

  logic [CNT_W-1:0] tickCnt;
  logic             selLong;
  logic [CNT_W-1:0] lastVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      selLong <= 1'b0;
    end else if (ctrl.startRun) begin
      tickCnt <= '0;
      selLong <= longSel;
    end else if (ctrl.countEn && tick) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  assign lastVal  = selLong ? LONG_LAST : SHORT_LAST;
  assign lastTick = ctrl.countEn && tick && (tickCnt == lastVal);

endmodule

// File: rtl/srg_control.sv
module srg_control
  import srg_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     lowLine,
  input  logic     wdTimeout,
  input  logic     lastTick,
  output srgCtrl_t ctrl,
  output logic     resetN,
  output logic     resetP,
  output logic     wdRestart
);
  srgState_t state, nextState;

  always_comb begin
    nextState     = state;
    ctrl.startRun = 1'b0;
    ctrl.countEn  = 1'b0;
    if (lowLine) begin
      nextState = ST_HOLD;
    end else begin
      unique case (state)
        ST_HOLD: begin
          nextState     = ST_STRETCH;
          ctrl.startRun = 1'b1;
        end
        ST_STRETCH: begin
          ctrl.countEn = 1'b1;
          if (lastTick) nextState = ST_RUN;
        end
        ST_RUN: begin
          if (wdTimeout) begin
            nextState     = ST_STRETCH;
            ctrl.startRun = 1'b1;
          end
        end
        default: nextState = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_HOLD;
      resetN    <= 1'b0;
      resetP    <= 1'b1;
      wdRestart <= 1'b0;
    end else begin
      state     <= nextState;
      resetN    <= (nextState == ST_RUN);
      resetP    <= (nextState != ST_RUN);
      wdRestart <= (state == ST_STRETCH) && (nextState == ST_RUN);
    end
  end

endmodule

// File: rtl/supply_reset_gen.sv
module supply_reset_gen
  import srg_pkg::*;
#(
  parameter int SHORT_TICKS = 512,
  parameter int LONG_TICKS  = 2048
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic lowLine,
  input  logic wdTimeout,
  input  logic longSel,
  output logic resetN,
  output logic resetP,
  output logic wdRestart
);
  srgCtrl_t ctrl;
  logic     lastTick;

  srg_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lowLine   (lowLine),
    .wdTimeout (wdTimeout),
    .lastTick  (lastTick),
    .ctrl      (ctrl),
    .resetN    (resetN),
    .resetP    (resetP),
    .wdRestart (wdRestart)
  );

  srg_datapath #(
    .SHORT_TICKS (SHORT_TICKS),
    .LONG_TICKS  (LONG_TICKS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .longSel  (longSel),
    .ctrl     (ctrl),
    .lastTick (lastTick)
  );

endmodule

// File: rtl/srg_checker.sv
module srg_checker (
  input logic clk,
  input logic rstN,
  input logic lowLine,
  input logic wdTimeout,
  input logic resetN,
  input logic resetP,
  input logic wdRestart
);
  // R1
  low_holds_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowLine |=> !resetN);

  // R5
  wd_fires_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resetN && wdTimeout && !lowLine) |=> !resetN);

  // R8
  polarity_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetP != resetN);

  // R9
  restart_on_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetN) |-> wdRestart);

  // R9
  restart_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdRestart |=> !wdRestart);

  // R9
  restart_only_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdRestart |-> resetN);

endmodule

bind supply_reset_gen srg_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .lowLine   (lowLine),
  .wdTimeout (wdTimeout),
  .resetN    (resetN),
  .resetP    (resetP),
  .wdRestart (wdRestart)
);

// File: tb/supply_reset_gen_test.sv
`timescale 1ns/1ps
module supply_reset_gen_test;
  localparam int SHORT_N = 512;
  localparam int LONG_N  = 2048;

  typedef struct {
    int    cycle;
    string req;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic lowLine = 1'b0;
  logic wdTimeout = 1'b0;
  logic longSel = 1'b0;
  logic resetN, resetP, wdRestart;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  expItem_t expQ[$];
  bit done = 1'b0;

  supply_reset_gen uut (
    .clk(clk), .rstN(rstN), .tick(tick), .lowLine(lowLine),
    .wdTimeout(wdTimeout), .longSel(longSel),
    .resetN(resetN), .resetP(resetP), .wdRestart(wdRestart)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // timebase: tick on edges whose number is a multiple of 3
  always @(negedge clk) tick <= ((cyc + 1) % 3 == 0);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // nth tick edge strictly after the trigger edge
  function automatic int releaseAt(input int trig, input int n);
    return (trig / 3 + n) * 3;
  endfunction

  task automatic expectRelease(input int trig, input int n, input string req);
    expItem_t it;
    it.cycle = releaseAt(trig, n);
    it.req   = req;
    expQ.push_back(it);
  endtask

  task automatic waitEmpty();
    while (expQ.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  // monitor: scoreboard pop on each release
  logic prevN = 1'b0;
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (resetP == resetN) check(1'b0, "R8", resetP, !resetN);
      if (resetN && !prevN) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6/R7 unexpected release", cyc, -1);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(cyc == it.cycle, it.req, cyc, it.cycle);
          check(wdRestart == 1'b1, "R9 strobe at release", wdRestart, 1);
        end
      end else if (wdRestart) begin
        check(1'b0, "R9 stray strobe", wdRestart, 0);
      end
    end
    prevN <= resetN;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog timeout", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int trig;
    // R10 reset state
    repeat (4) @(negedge clk);
    check(resetN == 1'b0, "R10 resetN", resetN, 0);
    check(resetP == 1'b1, "R10 resetP", resetP, 1);
    check(wdRestart == 1'b0, "R10 wdRestart", wdRestart, 0);
    rstN = 1'b1;
    trig = cyc + 1;
    expectRelease(trig, SHORT_N, "R10 power-on stretch");
    waitEmpty();

    // R1 / R2: low supply hold then short stretch
    lowLine = 1'b1;
    repeat (2) @(negedge clk);
    check(resetN == 1'b0, "R1 assert", resetN, 0);
    repeat (100) @(negedge clk);
    check(resetN == 1'b0, "R1 hold", resetN, 0);
    lowLine = 1'b0;
    trig = cyc + 1;
    expectRelease(trig, SHORT_N, "R2 short stretch");
    waitEmpty();

    // R3: long stretch
    longSel = 1'b1;
    @(negedge clk) lowLine = 1'b1;
    repeat (10) @(negedge clk);
    lowLine = 1'b0;
    trig = cyc + 1;
    expectRelease(trig, LONG_N, "R3 long stretch");
    waitEmpty();

    // R4: select changed mid-stretch is not followed
    @(negedge clk) lowLine = 1'b1;
    repeat (10) @(negedge clk);
    lowLine = 1'b0;
    trig = cyc + 1;
    expectRelease(trig, LONG_N, "R4 captured select");
    repeat (30) @(negedge clk);
    longSel = 1'b0;
    waitEmpty();

    // R5: watchdog request while running
    wdTimeout = 1'b1;
    trig = cyc + 1;
    expectRelease(trig, SHORT_N, "R5 watchdog pulse");
    @(negedge clk) wdTimeout = 1'b0;
    @(negedge clk);
    check(resetN == 1'b0, "R5 assert", resetN, 0);
    waitEmpty();

    // R6: second request during the pulse is ignored
    wdTimeout = 1'b1;
    trig = cyc + 1;
    expectRelease(trig, SHORT_N, "R6 request absorbed");
    @(negedge clk) wdTimeout = 1'b0;
    repeat (300) @(negedge clk);
    wdTimeout = 1'b1;
    @(negedge clk) wdTimeout = 1'b0;
    waitEmpty();

    // R7: low-line glitch mid-stretch restarts the count
    @(negedge clk) lowLine = 1'b1;
    repeat (5) @(negedge clk);
    lowLine = 1'b0;
    repeat (600) @(negedge clk);
    lowLine = 1'b1;
    repeat (20) @(negedge clk);
    check(resetN == 1'b0, "R7 held during glitch", resetN, 0);
    lowLine = 1'b0;
    trig = cyc + 1;
    expectRelease(trig, SHORT_N, "R7 restarted stretch");
    waitEmpty();

    // R9: strobe gone one clock after release
    check(wdRestart == 1'b0, "R9 strobe cleared", wdRestart, 0);
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule